// File: doc/BRIEF.md
# Port Event Qualifier and Rate Limiter

This block turns noisy per-channel trigger levels from a sensor/actuator port into a calm stream of event reports. Each channel sees two pre-compared inputs: one that is high while the monitored quantity is past its set threshold, and one that is high while it is back past its release threshold. A channel only reports a raise after the set input has persisted for a programmable number of tick strobes. It only reports a release after the release input has persisted in the same way. A level hovering between the two thresholds therefore cannot toggle the channel.

Every channel owns a small token bucket that caps how often it may report. Occurrences that cannot be reported at once, because tokens are exhausted, the output is stalled or another channel holds the slot, are merged into one pending entry that carries an occurrence count. Channels take turns at the output in round-robin order, so one noisy channel cannot take reporting capacity from the others. Running totals of raise and release occurrences allow the most frequent event kinds to be ranked.

The output is a valid/ready stream. An event stays on the output, unchanged, until it is accepted. While ready is low, newly qualified occurrences pile into the pending counts. Configuration is a plain write strobe with two value buses.

Top module: `evt_limiter`

## Requirements
- R1: While a channel is idle, a raise occurrence (ev_type=1) qualifies in the cycle where set_hit is still high and has been high through cfg_dwell tick strobes since it rose. With tick high every cycle, this means set_hit must stay high for cfg_dwell+1 cycles. Shorter pulses produce nothing. The event becomes valid two cycles after the qualifying cycle.
- R2: While a channel is active, only clr_hit, held under the same dwell rule, qualifies a release occurrence (ev_type=0) and returns the channel to idle. A raised channel with set_hit high or with both inputs low produces no event.
- R3: Each channel holds up to 4 tokens and is full after reset. Each emitted event uses one token. A channel with no tokens emits nothing. One token is added, up to the cap, each time cfg_refill tick strobes have been counted (every tick when cfg_refill is 0 or 1).
- R4: Occurrences that are not emitted at once merge into one pending entry per channel. That entry is emitted as one event whose ev_cnt is the number of merged occurrences and whose ev_type is that of the latest occurrence. It is emitted ahead of any occurrence that follows it.
- R5: The merged occurrence count saturates at 255 and does not wrap.
- R6: While ev_valid is high and ev_ready is low, ev_valid stays high and ev_ch, ev_type and ev_cnt keep their values.
- R7: Channels with pending entries and tokens are served in round-robin order. A channel with no tokens does not delay another channel's event.
- R8: A configuration write clears every dwell counter and every refill counter. No event is launched into the output register in the write cycle.
- R9: raise_total and clear_total count every qualified raise and release occurrence on all channels, whether or not the occurrence was emitted or merged. Both counters saturate.
- R10: After reset, ev_valid is low and both totals are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe for dwell and refill counting |
| set_hit | input | NCH | Per channel: level beyond the set threshold |
| clr_hit | input | NCH | Per channel: level beyond the release threshold |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dwell | input | DW | Dwell length in ticks |
| cfg_refill | input | RW | Token refill interval in ticks |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_ch | output | clog2(NCH) | Channel of the event |
| ev_type | output | 1 | 1 = raise, 0 = release |
| ev_cnt | output | CW | Number of merged occurrences |
| raise_total | output | TW | Saturating count of raise occurrences |
| clear_total | output | TW | Saturating count of release occurrences |

## Verification
The assertions assume that set_hit and clr_hit of one channel are never high together, since the thresholds of a channel cannot both be crossed. They also assume that ev_ready and the configuration inputs change only between clock edges. The stimulus drives every input a few nanoseconds after the rising edge. It never raises both hit inputs of one channel in the same cycle. It issues configuration writes only as single-cycle strobes while the channel under test is settled.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic {
    EV_CLEAR = 1'b0,
    EV_RAISE = 1'b1
  } ev_kind_e;
endpackage

// File: rtl/evt_qual.sv
module evt_qual
  import evt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_we,
  input  logic [DW-1:0] dwell,
  input  logic          set_hit,
  input  logic          clr_hit,
  output logic          qual,
  output ev_kind_e      kind
);
  logic [DW-1:0] cnt;
  logic          active_q;
  logic          cond;

  // idle channels watch the set side, raised channels only the release side
  assign cond = active_q ? clr_hit : set_hit;
  assign qual = !cfg_we && cond && (cnt >= dwell);
  assign kind = active_q ? EV_CLEAR : EV_RAISE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      active_q <= 1'b0;
    end else if (cfg_we || !cond) begin
      cnt <= '0;
    end else if (qual) begin
      active_q <= ~active_q;
      cnt      <= '0;
    end else if (tick && cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_raise_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(set_hit));
  assert_release_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(clr_hit));
  assert_cfg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cnt == '0);
endmodule

// File: rtl/evt_throttle.sv
module evt_throttle
  import evt_pkg::*;
#(
  parameter int RW      = 16,
  parameter int CW      = 8,
  parameter int MAX_TOK = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_we,
  input  logic [RW-1:0] refill,
  input  logic          qual,
  input  ev_kind_e      kind_in,
  input  logic          grant,
  output logic          req,
  output logic [CW-1:0] pend_cnt,
  output ev_kind_e      pend_kind
);
  localparam int TKW = $clog2(MAX_TOK + 1);

  logic [RW-1:0]  rcnt;
  logic [RW:0]    rcnt_nx;
  logic           refill_now;
  logic [TKW-1:0] tokens;

  assign rcnt_nx    = {1'b0, rcnt} + 1'b1;
  assign refill_now = tick && !cfg_we && (rcnt_nx >= {1'b0, refill});
  assign req        = (pend_cnt != '0) && (tokens != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_we) begin
      rcnt <= '0;
    end else if (tick) begin
      rcnt <= refill_now ? '0 : rcnt_nx[RW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tokens <= TKW'(MAX_TOK);
    end else begin
      case ({grant, refill_now})
        2'b10:   tokens <= tokens - 1'b1;
        2'b01:   if (tokens < TKW'(MAX_TOK)) tokens <= tokens + 1'b1;
        default: tokens <= tokens;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cnt  <= '0;
      pend_kind <= EV_CLEAR;
    end else if (grant) begin
      pend_cnt <= qual ? CW'(1) : '0;
      if (qual) pend_kind <= kind_in;
    end else if (qual) begin
      if (pend_cnt != '1) pend_cnt <= pend_cnt + 1'b1;
      pend_kind <= kind_in;
    end
  end

  assert_grant_token_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> tokens != '0);
  assert_token_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tokens <= TKW'(MAX_TOK));
  assert_pend_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '1 && qual && !grant) |=> pend_cnt == '1);
endmodule

// File: rtl/evt_rr_pick.sv
module evt_rr_pick #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           en,
  output logic [NCH-1:0] grant,
  output logic [CHW-1:0] pick,
  output logic           any
);
  logic [CHW-1:0] ptr;

  always_comb begin
    grant = '0;
    pick  = '0;
    any   = 1'b0;
    for (int off = 0; off < NCH; off++) begin
      int idx;
      idx = (int'(ptr) + off) % NCH;
      if (!any && req[idx]) begin
        any  = 1'b1;
        pick = CHW'(idx);
      end
    end
    if (any && en) grant[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (any && en) begin
      ptr <= (pick == CHW'(NCH - 1)) ? '0 : pick + 1'b1;
    end
  end

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/evt_limiter.sv
module evt_limiter
  import evt_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DW      = 16,
  parameter int RW      = 16,
  parameter int CW      = 8,
  parameter int TW      = 16,
  parameter int MAX_TOK = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tick,
  input  logic [NCH-1:0]                       set_hit,
  input  logic [NCH-1:0]                       clr_hit,
  input  logic                                 cfg_we,
  input  logic [DW-1:0]                        cfg_dwell,
  input  logic [RW-1:0]                        cfg_refill,
  output logic                                 ev_valid,
  input  logic                                 ev_ready,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ev_ch,
  output logic                                 ev_type,
  output logic [CW-1:0]                        ev_cnt,
  output logic [TW-1:0]                        raise_total,
  output logic [TW-1:0]                        clear_total
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SW  = CHW + 1;

  logic [DW-1:0]  dwell_q;
  logic [RW-1:0]  refill_q;
  logic [NCH-1:0] qual, req, grant;
  ev_kind_e       kind_a      [NCH];
  ev_kind_e       pend_kind_a [NCH];
  logic [CW-1:0]  pend_cnt_a  [NCH];
  logic [CHW-1:0] pick;
  logic           any, slot_free, launch_en;
  logic [SW-1:0]  n_raise, n_clear;
  logic [TW:0]    raise_sum, clear_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dwell_q  <= '0;
      refill_q <= '0;
    end else if (cfg_we) begin
      dwell_q  <= cfg_dwell;
      refill_q <= cfg_refill;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    evt_qual #(.DW(DW)) u_qual (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
      .dwell(dwell_q), .set_hit(set_hit[g]), .clr_hit(clr_hit[g]),
      .qual(qual[g]), .kind(kind_a[g])
    );
    evt_throttle #(.RW(RW), .CW(CW), .MAX_TOK(MAX_TOK)) u_thr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
      .refill(refill_q), .qual(qual[g]), .kind_in(kind_a[g]),
      .grant(grant[g]), .req(req[g]), .pend_cnt(pend_cnt_a[g]),
      .pend_kind(pend_kind_a[g])
    );
  end

  assign slot_free = !ev_valid || ev_ready;
  assign launch_en = slot_free && !cfg_we;

  evt_rr_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(req), .en(launch_en),
    .grant(grant), .pick(pick), .any(any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_ch    <= '0;
      ev_type  <= 1'b0;
      ev_cnt   <= '0;
    end else if (any && launch_en) begin
      ev_valid <= 1'b1;
      ev_ch    <= pick;
      ev_type  <= logic'(pend_kind_a[pick]);
      ev_cnt   <= pend_cnt_a[pick];
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end

  always_comb begin
    n_raise = '0;
    n_clear = '0;
    for (int c = 0; c < NCH; c++) begin
      if (qual[c]) begin
        if (kind_a[c] == EV_RAISE) n_raise = n_raise + SW'(1);
        else                       n_clear = n_clear + SW'(1);
      end
    end
  end

  assign raise_sum = {1'b0, raise_total} + (TW + 1)'(n_raise);
  assign clear_sum = {1'b0, clear_total} + (TW + 1)'(n_clear);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raise_total <= '0;
      clear_total <= '0;
    end else begin
      raise_total <= raise_sum[TW] ? '1 : raise_sum[TW-1:0];
      clear_total <= clear_sum[TW] ? '1 : clear_sum[TW-1:0];
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_ch) && $stable(ev_type) && $stable(ev_cnt)));
  assert_cfg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && slot_free) |=> !ev_valid);
  assert_cnt_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_cnt != '0);
endmodule

// File: tb/tb_evt_limiter.sv
module tb_evt_limiter;
  localparam int NCH = 4;
  localparam int N_VEC = 8;
  localparam int VEC_D [N_VEC] = '{0, 3, 3, 5, 5, 7, 7, 2};
  localparam int VEC_L [N_VEC] = '{1, 3, 4, 2, 6, 7, 10, 20};
  localparam int VEC_E [N_VEC] = '{1, 0, 1, 0, 1, 0, 1, 1};

  logic clk = 0, rst_n = 0, tick = 1, cfg_we = 0, ev_ready = 1;
  logic [NCH-1:0] set_hit = '0, clr_hit = '0;
  logic [15:0] cfg_dwell = '0, cfg_refill = '0;
  logic ev_valid, ev_type;
  logic [1:0] ev_ch;
  logic [7:0] ev_cnt;
  logic [15:0] raise_total, clear_total;

  int errors = 0, checks = 0;
  int hs [NCH], sumc [NCH], lastc [NCH], lastt [NCH];
  int nclr [NCH];
  bit done = 0;

  always #10 clk = ~clk;

  evt_limiter dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .set_hit(set_hit), .clr_hit(clr_hit),
    .cfg_we(cfg_we), .cfg_dwell(cfg_dwell), .cfg_refill(cfg_refill),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_ch(ev_ch), .ev_type(ev_type),
    .ev_cnt(ev_cnt), .raise_total(raise_total), .clear_total(clear_total)
  );

  initial for (int i = 0; i < NCH; i++) begin hs[i] = 0; sumc[i] = 0; lastc[i] = 0; lastt[i] = 0; nclr[i] = 0; end

  always @(negedge clk) if (rst_n && ev_valid && ev_ready) begin
    hs[ev_ch]++; sumc[ev_ch] += int'(ev_cnt);
    lastc[ev_ch] = int'(ev_cnt); lastt[ev_ch] = int'(ev_type);
    if (!ev_type) nclr[ev_ch]++;
  end

  task automatic step(); @(posedge clk); #5; endtask
  task automatic steps(input int n); for (int i = 0; i < n; i++) step(); endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int d, input int r);
    cfg_dwell = 16'(d); cfg_refill = 16'(r); cfg_we = 1; step(); cfg_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    finish_run();
  end

  initial begin
    int h0, c0, r0, k0;
    steps(3); rst_n = 1; step();
    check("R10 ev_valid after reset", int'(ev_valid), 0);
    check("R10 raise_total after reset", int'(raise_total), 0);
    check("R10 clear_total after reset", int'(clear_total), 0);

    // debounce vectors on channel 0
    for (int v = 0; v < N_VEC; v++) begin
      cfg(VEC_D[v], 1);
      h0 = hs[0]; c0 = nclr[0];
      set_hit[0] = 1; steps(VEC_L[v]); set_hit[0] = 0; steps(6);
      check("R1 raise after pulse", hs[0] - h0, VEC_E[v]);
      clr_hit[0] = 1; steps(VEC_D[v] + 3); clr_hit[0] = 0; steps(6);
      check("R2 release after raise", nclr[0] - c0, VEC_E[v]);
    end

    // token cap and merging on channel 1
    cfg(0, 1000);
    h0 = hs[1]; c0 = sumc[1]; r0 = int'(raise_total); k0 = int'(clear_total);
    for (int i = 0; i < 6; i++) begin
      set_hit[1] = (i % 2 == 0); clr_hit[1] = (i % 2 == 1); step();
    end
    set_hit[1] = 0; clr_hit[1] = 0; steps(10);
    check("R3 four tokens then stop", hs[1] - h0, 4);
    steps(1010);
    check("R3 refill releases one event", hs[1] - h0, 5);
    check("R4 merged count", lastc[1], 2);
    check("R4 merged type is latest", lastt[1], 0);
    check("R4 no occurrence lost", sumc[1] - c0, 6);
    check("R9 raise total", int'(raise_total) - r0, 3);
    check("R9 clear total", int'(clear_total) - k0, 3);

    // fairness: channel 1 starved of tokens, channel 2 still served
    h0 = hs[1]; c0 = hs[2];
    set_hit[1] = 1; step(); set_hit[1] = 0;
    set_hit[2] = 1; step(); set_hit[2] = 0; steps(6);
    check("R7 empty channel silent", hs[1] - h0, 0);
    check("R7 other channel served", hs[2] - c0, 1);

    // back-pressure and saturation on channel 3
    cfg(0, 1); steps(6);
    ev_ready = 0; h0 = hs[3];
    set_hit[3] = 1; step();
    for (int i = 1; i <= 300; i++) begin
      set_hit[3] = (i % 2 == 0); clr_hit[3] = (i % 2 == 1); step();
    end
    set_hit[3] = 0; clr_hit[3] = 0; step();
    check("R6 valid held", int'(ev_valid), 1);
    check("R6 channel held", int'(ev_ch), 3);
    check("R6 count held", int'(ev_cnt), 1);
    ev_ready = 1; steps(6);
    check("R6 both delivered", hs[3] - h0, 2);
    check("R5 saturated count", lastc[3], 255);
    check("R4 latest type after merge", lastt[3], 1);

    // hysteresis: raised channel 3 ignores set side and the middle band
    h0 = hs[3];
    set_hit[3] = 1; steps(20); set_hit[3] = 0; steps(20);
    check("R2 no event between thresholds", hs[3] - h0, 0);
    clr_hit[3] = 1; steps(3); clr_hit[3] = 0; steps(6);
    check("R2 release only via clr_hit", hs[3] - h0, 1);
    check("R2 release type", lastt[3], 0);

    // configuration write restarts dwell on channel 0
    cfg(5, 1); steps(2);
    set_hit[0] = 1; steps(3);
    cfg_we = 1; step(); cfg_we = 0;
    steps(6);
    check("R8 dwell restarted, not yet valid", int'(ev_valid), 0);
    step();
    check("R8 valid after full dwell", int'(ev_valid), 1);
    check("R1 channel of event", int'(ev_ch), 0);
    check("R1 raise type", int'(ev_type), 1);
    set_hit[0] = 0; steps(4);

    finish_run();
  end
endmodule